// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This block sits beside a multithreaded pipeline and gives each hardware thread instructions whose meaning involves time. A free-running counter holds the current time in nanoseconds. It advances by a fixed step every clock. Each thread owns a bank of deadline registers. A decoded command can load a deadline as "now plus an offset". It can hold the thread until a deadline is reached, or test a deadline for a branch. It can arm a numbered exception slot against a deadline, disarm such a slot, or enforce an exact finishing time and flag a miss.

Four timing policies can be built from these commands. Best-effort waiting uses set followed by delay. Late detection uses set followed by a branch test. Immediate detection uses an armed slot that raises a request as soon as the deadline passes. Exact completion uses the exact command, which stalls an early thread and reports a late one.

Each thread runs a small state machine with three states. **RUN** is the state in which commands are accepted. **HOLD_DELAY** is entered from RUN when a delay command finds its deadline not yet reached. **HOLD_EXACT** is entered from RUN when an exact command finds its deadline not yet reached. Both hold states go back to RUN on the clock edge that ends the first cycle in which the current time is greater than or equal to the captured deadline.

Top module: `deadline_timer_unit`

## Requirements
- R1: After reset the time base reads 0. No thread stalls. br_valid, every viol bit and every exc_req bit are 0. All deadlines are 0 and all slots are disarmed.
- R2: now_ns increases by NS_STEP (default 10) on every clock edge after reset.
- R3: Op 1 (set) loads register cmd_reg of thread cmd_tid with the now_ns of the issue cycle plus cmd_offset.
- R4: Op 2 (delay) with deadline D issued at time T stalls the thread from the next cycle, through every cycle in which now_ns < D. Stall is low in the first cycle with now_ns >= D. If T >= D there is no stall at all.
- R5: Op 3 (branch test) drives br_valid high in the next cycle. In that cycle br_taken is 1 exactly when T >= D.
- R6: Op 4 (arm) binds slot cmd_slot to register cmd_reg. On any edge where an armed slot's deadline satisfies now_ns >= D, the slot becomes pending and disarms itself. A pending slot keeps exc_req high until it is acknowledged.
- R7: Op 5 (disarm) clears both the armed flag and the pending flag of slot cmd_slot. A later expiry then raises nothing.
- R8: Op 6 (exact) stalls exactly as R4 when T < D. It pulses viol for one cycle, the cycle after issue, when T > D. When T == D it neither stalls nor pulses.
- R9: A command addressed to a thread that is not in RUN has no effect.
- R10: exc_idx shows the lowest-numbered pending slot, or 0 when none is pending. An exc_ack pulse clears only that slot.
- R11: Commands, stalls and exceptions of one thread never change the outputs of another thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_tid | input | TIDW | Target thread |
| cmd_op | input | 3 | 0 none, 1 set, 2 delay, 3 branch test, 4 arm, 5 disarm, 6 exact |
| cmd_reg | input | RIDW | Deadline register index |
| cmd_slot | input | SIDW | Exception slot index |
| cmd_offset | input | TW | Offset in ns for set |
| exc_ack | input | NT | Per-thread acknowledge of the shown exception |
| now_ns | output | TW | Current time base |
| stall | output | NT | Per-thread stall |
| br_valid | output | 1 | Branch test result valid |
| br_taken | output | 1 | Branch test result: deadline reached |
| viol | output | NT | Per-thread exact-completion miss pulse |
| exc_req | output | NT | Per-thread exception request |
| exc_idx | output | NT*SIDW | Per-thread pending slot number, thread t at bits [t*SIDW +: SIDW] |

## Verification
The checker assumes that at most one command arrives per cycle and that cmd_tid names an existing thread. The bench never drives a thread index outside the thread count. It draws every command from a single random stream, so no two commands can meet in the same cycle. The properties relate a stall rise, a viol pulse or a br_valid to a command one cycle earlier. They also assume that exc_ack is raised only while that thread's exc_req is high. The bench acknowledges only when its own model shows a pending slot, and it keeps offsets small so that stalls end well inside the run.

// File: rtl/tgu_pkg.sv
package tgu_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SET    = 3'd1,
        OP_DELAY  = 3'd2,
        OP_BRTEST = 3'd3,
        OP_ARM    = 3'd4,
        OP_DISARM = 3'd5,
        OP_EXACT  = 3'd6
    } tgu_op_e;

    typedef enum logic [1:0] {
        TS_RUN,
        TS_HOLD_DELAY,
        TS_HOLD_EXACT
    } tgu_state_e;

endpackage

// File: rtl/tgu_timebase.sv
module tgu_timebase #(
    parameter int TW      = 64,
    parameter int NS_STEP = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] now
);
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + TW'(NS_STEP);
    end
endmodule

// File: rtl/tgu_first.sv
module tgu_first #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/tgu_thread.sv
module tgu_thread
    import tgu_pkg::*;
#(
    parameter int TW     = 64,
    parameter int NREGS  = 8,
    parameter int NSLOTS = 4,
    parameter int RIDW   = 3,
    parameter int SIDW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   now,
    input  logic            hit,
    input  logic [2:0]      op,
    input  logic [RIDW-1:0] rsel,
    input  logic [SIDW-1:0] ssel,
    input  logic [TW-1:0]   offset,
    input  logic            ack,
    output logic            stall,
    output logic            brv,
    output logic            brt,
    output logic            viol,
    output logic            exc_req,
    output logic [SIDW-1:0] exc_idx
);
    tgu_op_e         op_e;
    tgu_state_e      state, state_nxt;
    logic [TW-1:0]   hold;
    logic [TW-1:0]   dl [NREGS];
    logic [TW-1:0]   rd_dl;
    logic            accept;
    logic            reached;
    logic [NSLOTS-1:0] armed, pending;
    logic            pick_any;
    logic [SIDW-1:0] pick_idx;

    assign op_e    = tgu_op_e'(op);
    assign accept  = hit && (state == TS_RUN);
    assign rd_dl   = dl[rsel];
    assign reached = (now >= rd_dl);

    // deadline bank
    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic [TW-1:0] dl_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dl_q <= '0;
            end else if (accept && op_e == OP_SET && rsel == RIDW'(r)) begin
                dl_q <= now + offset;
            end
        end
        assign dl[r] = dl_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_RUN;
        else        state <= state_nxt;
    end

    // captured deadline for the hold states
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (state == TS_RUN && state_nxt != TS_RUN) begin
            hold <= rd_dl;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            TS_RUN: begin
                if (accept && op_e == OP_DELAY && !reached)
                    state_nxt = TS_HOLD_DELAY;
                else if (accept && op_e == OP_EXACT && !reached)
                    state_nxt = TS_HOLD_EXACT;
            end
            TS_HOLD_DELAY: begin
                if (now >= hold) state_nxt = TS_RUN;
            end
            TS_HOLD_EXACT: begin
                if (now >= hold) state_nxt = TS_RUN;
            end
            default: state_nxt = TS_RUN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        stall = (state != TS_RUN) && (now < hold);
    end

    // branch test and exact-miss results, one cycle after issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brv  <= 1'b0;
            brt  <= 1'b0;
            viol <= 1'b0;
        end else begin
            brv  <= accept && op_e == OP_BRTEST;
            brt  <= accept && op_e == OP_BRTEST && reached;
            viol <= accept && op_e == OP_EXACT && (now > rd_dl);
        end
    end

    // exception slots
    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        logic            armed_q, pend_q;
        logic [RIDW-1:0] sreg_q;
        logic            fire, arm_s, dis_s, clr_s;
        assign fire  = armed_q && (now >= dl[sreg_q]);
        assign arm_s = accept && op_e == OP_ARM && ssel == SIDW'(s);
        assign dis_s = accept && op_e == OP_DISARM && ssel == SIDW'(s);
        assign clr_s = ack && pick_any && pick_idx == SIDW'(s);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q <= 1'b0;
                pend_q  <= 1'b0;
                sreg_q  <= '0;
            end else begin
                if (clr_s) pend_q <= 1'b0;
                if (fire) begin
                    pend_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
                if (arm_s) begin
                    armed_q <= 1'b1;
                    sreg_q  <= rsel;
                end
                if (dis_s) begin
                    armed_q <= 1'b0;
                    pend_q  <= 1'b0;
                end
            end
        end
        assign armed[s]   = armed_q;
        assign pending[s] = pend_q;
    end

    tgu_first #(.N(NSLOTS), .IW(SIDW)) u_pick (
        .req (pending),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign exc_req = pick_any;
    assign exc_idx = pick_idx;
endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit #(
    parameter int NT      = 2,
    parameter int TW      = 64,
    parameter int NREGS   = 8,
    parameter int NSLOTS  = 4,
    parameter int NS_STEP = 10,
    parameter int TIDW    = (NT > 1) ? $clog2(NT) : 1,
    parameter int RIDW    = (NREGS > 1) ? $clog2(NREGS) : 1,
    parameter int SIDW    = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [TIDW-1:0]    cmd_tid,
    input  logic [2:0]         cmd_op,
    input  logic [RIDW-1:0]    cmd_reg,
    input  logic [SIDW-1:0]    cmd_slot,
    input  logic [TW-1:0]      cmd_offset,
    input  logic [NT-1:0]      exc_ack,
    output logic [TW-1:0]      now_ns,
    output logic [NT-1:0]      stall,
    output logic               br_valid,
    output logic               br_taken,
    output logic [NT-1:0]      viol,
    output logic [NT-1:0]      exc_req,
    output logic [NT*SIDW-1:0] exc_idx
);
    logic [NT-1:0] brv_t, brt_t;

    tgu_timebase #(.TW(TW), .NS_STEP(NS_STEP)) u_time (
        .clk (clk),
        .rst_n (rst_n),
        .now (now_ns)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic hit;
        assign hit = cmd_valid && (cmd_tid == TIDW'(t));
        tgu_thread #(
            .TW(TW), .NREGS(NREGS), .NSLOTS(NSLOTS), .RIDW(RIDW), .SIDW(SIDW)
        ) u_thr (
            .clk     (clk),
            .rst_n   (rst_n),
            .now     (now_ns),
            .hit     (hit),
            .op      (cmd_op),
            .rsel    (cmd_reg),
            .ssel    (cmd_slot),
            .offset  (cmd_offset),
            .ack     (exc_ack[t]),
            .stall   (stall[t]),
            .brv     (brv_t[t]),
            .brt     (brt_t[t]),
            .viol    (viol[t]),
            .exc_req (exc_req[t]),
            .exc_idx (exc_idx[t*SIDW +: SIDW])
        );
    end

    assign br_valid = |brv_t;
    assign br_taken = |brt_t;
endmodule

// File: rtl/tgu_checker.sv
module tgu_checker #(
    parameter int NT      = 2,
    parameter int TW      = 64,
    parameter int NS_STEP = 10,
    parameter int TIDW    = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [TIDW-1:0] cmd_tid,
    input logic [2:0]      cmd_op,
    input logic [NT-1:0]   exc_ack,
    input logic [TW-1:0]   now_ns,
    input logic [NT-1:0]   stall,
    input logic            br_valid,
    input logic [NT-1:0]   viol,
    input logic [NT-1:0]   exc_req
);
    logic started;
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (now_ns == $past(now_ns) + TW'(NS_STEP)));

    assert_brv_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> $past(cmd_valid && cmd_op == 3'd3));

    for (genvar t = 0; t < NT; t++) begin : g_chk
        assert_viol_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            viol[t] |-> $past(cmd_valid && cmd_op == 3'd6 && cmd_tid == TIDW'(t)));

        assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stall[t]) |-> $past(cmd_valid && cmd_tid == TIDW'(t)
                                      && (cmd_op == 3'd2 || cmd_op == 3'd6)));

        assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (exc_req[t] && !exc_ack[t]
             && !(cmd_valid && cmd_tid == TIDW'(t) && cmd_op == 3'd5))
            |=> exc_req[t]);
    end
endmodule

bind deadline_timer_unit tgu_checker #(
    .NT(NT), .TW(TW), .NS_STEP(NS_STEP), .TIDW(TIDW)
) u_tgu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_tid   (cmd_tid),
    .cmd_op    (cmd_op),
    .exc_ack   (exc_ack),
    .now_ns    (now_ns),
    .stall     (stall),
    .br_valid  (br_valid),
    .viol      (viol),
    .exc_req   (exc_req)
);

// File: tb/test_deadline_timer_unit.sv
`timescale 1ns/1ps
module test_deadline_timer_unit;
    localparam int NT = 2, NR = 8, NS = 4, STEP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [0:0]  cmd_tid = '0;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_reg = '0;
    logic [1:0]  cmd_slot = '0;
    logic [63:0] cmd_offset = '0;
    logic [1:0]  exc_ack = '0;
    logic [63:0] now_ns;
    logic [1:0]  stall, viol, exc_req;
    logic        br_valid, br_taken;
    logic [3:0]  exc_idx;

    deadline_timer_unit i_deadline_timer_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_tid(cmd_tid),
        .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_slot(cmd_slot),
        .cmd_offset(cmd_offset), .exc_ack(exc_ack), .now_ns(now_ns),
        .stall(stall), .br_valid(br_valid), .br_taken(br_taken), .viol(viol),
        .exc_req(exc_req), .exc_idx(exc_idx)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;
    bit ack_rand = 0;
    logic [1:0] ack_force = '0;
    string tag = "R1";

    longint unsigned now_m;
    longint unsigned m_dl   [NT][NR];
    longint unsigned m_hold [NT];
    int              m_st   [NT];
    bit              m_arm  [NT][NS];
    bit              m_pend [NT][NS];
    int              m_sreg [NT][NS];
    bit              m_brv, m_brt;
    bit              m_viol [NT];

    function automatic bit exp_req(int t);
        bit r = 0;
        for (int s = 0; s < NS; s++) r |= m_pend[t][s];
        return r;
    endfunction

    function automatic int exp_idx(int t);
        for (int s = 0; s < NS; s++) if (m_pend[t][s]) return s;
        return 0;
    endfunction

    function automatic bit exp_stall(int t);
        return (m_st[t] != 0) && (now_m < m_hold[t]);
    endfunction

    task automatic chk(string what, longint unsigned act, longint unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", what, tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        now_m = 0;
        m_brv = 0; m_brt = 0;
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_hold[t] = 0; m_viol[t] = 0;
            for (int r = 0; r < NR; r++) m_dl[t][r] = 0;
            for (int s = 0; s < NS; s++) begin
                m_arm[t][s] = 0; m_pend[t][s] = 0; m_sreg[t][s] = 0;
            end
        end
    endtask

    task automatic check_outputs();
        chk("now_ns R2", now_ns, now_m);
        chk("br_valid R5", br_valid, m_brv);
        chk("br_taken R5", br_taken, m_brt);
        for (int t = 0; t < NT; t++) begin
            chk($sformatf("stall[%0d] R4 R8 R11", t), stall[t], exp_stall(t));
            chk($sformatf("viol[%0d] R8", t), viol[t], m_viol[t]);
            chk($sformatf("exc_req[%0d] R6 R7", t), exc_req[t], exp_req(t));
            chk($sformatf("exc_idx[%0d] R10", t), exc_idx[t*2 +: 2], exp_idx(t));
        end
    endtask

    task automatic model_update();
        bit nbrv = 0, nbrt = 0;
        for (int t = 0; t < NT; t++) begin
            bit hit = cmd_valid && (cmd_tid == t);
            bit acc = hit && (m_st[t] == 0);
            longint unsigned rdl = m_dl[t][cmd_reg];
            bit req = exp_req(t);
            int idx = exp_idx(t);
            for (int s = 0; s < NS; s++) begin
                bit fire = m_arm[t][s] && (now_m >= m_dl[t][m_sreg[t][s]]);
                if (exc_ack[t] && req && s == idx) m_pend[t][s] = 0;
                if (fire) begin m_pend[t][s] = 1; m_arm[t][s] = 0; end
                if (acc && cmd_op == 4 && cmd_slot == s) begin
                    m_arm[t][s] = 1; m_sreg[t][s] = cmd_reg;
                end
                if (acc && cmd_op == 5 && cmd_slot == s) begin
                    m_arm[t][s] = 0; m_pend[t][s] = 0;
                end
            end
            if (acc && cmd_op == 3) begin nbrv = 1; nbrt = (now_m >= rdl); end
            m_viol[t] = acc && cmd_op == 6 && (now_m > rdl);
            if (m_st[t] == 0) begin
                if (acc && (cmd_op == 2 || cmd_op == 6) && now_m < rdl) begin
                    m_st[t] = (cmd_op == 2) ? 1 : 2;
                    m_hold[t] = rdl;
                end
            end else if (now_m >= m_hold[t]) m_st[t] = 0;
            if (acc && cmd_op == 1) m_dl[t][cmd_reg] = now_m + cmd_offset;
        end
        m_brv = nbrv; m_brt = nbrt;
    endtask

    // called at a falling edge with the command already driven
    task automatic step();
        check_outputs();
        for (int t = 0; t < NT; t++)
            exc_ack[t] = ack_force[t] || (ack_rand && exp_req(t) && ($urandom % 3 == 0));
        model_update();
        @(posedge clk);
        now_m += STEP;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0; exc_ack = '0; ack_force = '0;
    endtask

    task automatic issue(int op, int tid, int rg, int sl, longint unsigned off);
        cmd_valid = 1; cmd_op = 3'(op); cmd_tid = 1'(tid);
        cmd_reg = 3'(rg); cmd_slot = 2'(sl); cmd_offset = off;
        step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        tag = "R1";
        idle(2);
        // R3 and R4: set then delay, then delay on an already-passed deadline
        tag = "R3";
        issue(1, 0, 1, 0, 100);
        issue(3, 0, 1, 0, 0);
        tag = "R4";
        issue(2, 0, 1, 0, 0);
        idle(12);
        issue(2, 0, 1, 0, 0);
        idle(2);
        // R9: commands to a stalled thread are dropped
        tag = "R9";
        issue(1, 0, 2, 0, 200);
        issue(2, 0, 2, 0, 0);
        issue(1, 0, 3, 0, 1000);
        issue(4, 0, 3, 0, 0);
        idle(22);
        issue(3, 0, 3, 0, 0);
        idle(3);
        // R8: on-time, late and early exact completion
        tag = "R8";
        issue(1, 0, 4, 0, 10);
        issue(6, 0, 4, 0, 0);
        issue(1, 0, 5, 0, 0);
        idle(2);
        issue(6, 0, 5, 0, 0);
        issue(1, 0, 6, 0, 80);
        issue(6, 0, 6, 0, 0);
        idle(10);
        // R6 and R10: two slots pending, held, acknowledged lowest first
        tag = "R10";
        issue(1, 1, 0, 0, 30);
        issue(1, 1, 1, 0, 20);
        issue(4, 1, 0, 2, 0);
        issue(4, 1, 1, 1, 0);
        idle(8);
        tag = "R6";
        ack_force = 2'b10; step();
        idle(2);
        ack_force = 2'b10; step();
        idle(2);
        // R7: disarm before expiry, and disarm of a pending slot
        tag = "R7";
        issue(1, 1, 2, 0, 50);
        issue(4, 1, 2, 3, 0);
        idle(1);
        issue(5, 1, 0, 3, 0);
        idle(8);
        issue(4, 1, 0, 0, 0);
        idle(3);
        issue(5, 1, 0, 0, 0);
        idle(2);
        // R11: random traffic on both threads
        tag = "R11";
        ack_rand = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 5 < 3) begin
                longint unsigned off = ($urandom % 8 == 0) ? 0 : longint'($urandom % 400);
                issue(1 + int'($urandom % 6), int'($urandom % NT), int'($urandom % NR),
                      int'($urandom % NS), off);
            end else begin
                step();
            end
        end
        ack_rand = 0;
        idle(50);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (phase %s) actual=hung expected=finished", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule